// File: doc/BRIEF.md
# Router I/O Controller Register Block

This block is the register front end of a modular router mainboard. A CPU reaches it over a plain synchronous register bus: an address, separate read and write strobes, a 16-bit write word and a registered 16-bit read word. Most of its words are fixed. These are the flash-protect and bootflash-size words, an environment word, and a chassis identification word whose model code comes from a strap input. One word reports which of the four module slots hold a card. Each slot's presence shows as four zero bits spread one nibble apart.

Two registers are writable. One is an 8-bit I/O mask. The other is the module EEPROM register: it selects one of the four slots and drives that slot's bit-banged serial EEPROM pins. A separate register drives the mainboard EEPROM in the same way. In both cases a read returns the device's data-out bit.

Three interrupt lines are set by one-cycle pulses from their sources. The CPU clears a line by touching its status register. The management and external lines clear on the first access. The network line has four status bytes, one per slot. A counter shared by those four bytes clears the network line only on every sixteenth access.

Top module: `rio_ctrl`

## Requirements
- R1: After reset all interrupt lines are low, the I/O mask is 0x00, every EEPROM output pin is low, the slot select is 0 and `rdata` is 0x0000.
- R2: Reads of fixed words return: address 0x00 gives 0x00FF, 0x01 gives 0x1000, 0x03 gives 0x0021, and 0x02 gives `chassis_code` in bits 7:5 with all other bits zero.
- R3: A read of address 0x04 returns 0xFFFF with, for every slot s whose `slot_detect[s]` is 1, bits s, s+4, s+8 and s+12 cleared.
- R4: Address 0x05 is the I/O mask: a write stores `wdata[7:0]`, and a read returns it in bits 7:0 with bits 15:8 zero.
- R5: A write to address 0x06 sets `mb_cs`, `mb_sk`, `mb_di` from `wdata` bits 0, 1 and 2. A read returns `mb_do` in bit 3 and zero elsewhere.
- R6: A write to address 0x07 takes the slot select from `wdata[1:0]` and drives that slot's chip select, clock and data-in from `wdata` bits 4, 2 and 6. The other slots' pins are low. A read returns the selected slot's `mod_do` bit in bit 7 and zero elsewhere.
- R7: Reads of addresses 0x08 to 0x0B, the network status bytes of slots 0 to 3, return 0x00FF.
- R8: A read or write to any of 0x08 to 0x0B advances one shared count. The 16th access since the count last restarted clears `net_irq` and restarts the count from zero. The count advances whether or not the line is high.
- R9: Any read or write to address 0x0C clears `mgmt_irq`. A read returns 0x0000.
- R10: Any read or write to address 0x0D clears `ext_irq`. A read returns 0x0000.
- R11: A one-cycle pulse on a source input sets its line at the next edge. When a set and a clear fall in the same cycle, the line stays high.
- R12: Reads of unmapped addresses (0x0E to 0x3F) return 0x0000. Writes to them, and writes to the fixed words, change no register, pin or line.
- R13: `rdata` carries the read word in the cycle after `rd_en` and is 0x0000 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 6 | Register address |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe, one access per cycle |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| chassis_code | input | 3 | Strapped chassis model code |
| slot_detect | input | 4 | Card detect per slot, high when a card is present |
| mb_cs | output | 1 | Mainboard EEPROM chip select |
| mb_sk | output | 1 | Mainboard EEPROM serial clock |
| mb_di | output | 1 | Mainboard EEPROM data in |
| mb_do | input | 1 | Mainboard EEPROM data out |
| mod_cs | output | 4 | Module EEPROM chip select per slot |
| mod_sk | output | 4 | Module EEPROM serial clock per slot |
| mod_di | output | 4 | Module EEPROM data in per slot |
| mod_do | input | 4 | Module EEPROM data out per slot |
| net_set | input | 1 | Network interrupt set pulse |
| mgmt_set | input | 1 | Management interrupt set pulse |
| ext_set | input | 1 | External interrupt set pulse |
| net_irq | output | 1 | Network interrupt line |
| mgmt_irq | output | 1 | Management interrupt line |
| ext_irq | output | 1 | External interrupt line |

## Verification
The assertions assume that `rd_en` and `wr_en` are never high in the same cycle. They also assume that the set inputs are single-cycle pulses sampled at the rising edge. The stimulus drives every access and pulse at the falling edge and releases it one cycle later, so each bus access is exactly one strobed cycle. Both strobes are never raised together. The sweeps cover all sixteen detect patterns, all eight model codes, all 256 mask values and every slot with every pin combination. The bench keeps its own count of network status accesses across the whole run, so it can predict the cycle in which the line clears.

// File: rtl/rio_pkg.sv
package rio_pkg;
  localparam int unsigned RIO_AW = 6;

  localparam logic [RIO_AW-1:0] A_FLASH   = 6'h00;
  localparam logic [RIO_AW-1:0] A_BOOT    = 6'h01;
  localparam logic [RIO_AW-1:0] A_CHASSIS = 6'h02;
  localparam logic [RIO_AW-1:0] A_ENV     = 6'h03;
  localparam logic [RIO_AW-1:0] A_PRES    = 6'h04;
  localparam logic [RIO_AW-1:0] A_MASK    = 6'h05;
  localparam logic [RIO_AW-1:0] A_MBEE    = 6'h06;
  localparam logic [RIO_AW-1:0] A_MODEE   = 6'h07;
  localparam logic [RIO_AW-1:0] A_NET0    = 6'h08;
  localparam logic [RIO_AW-1:0] A_MGMT    = 6'h0C;
  localparam logic [RIO_AW-1:0] A_EXT     = 6'h0D;

  localparam logic [15:0] FLASH_WORD = 16'h00FF;
  localparam logic [15:0] BOOT_WORD  = 16'h1000;
  localparam logic [15:0] ENV_WORD   = 16'h0021;
  localparam logic [15:0] NET_WORD   = 16'h00FF;

  // serial pin positions inside the two EEPROM registers
  localparam int unsigned MB_CS_B  = 0;
  localparam int unsigned MB_SK_B  = 1;
  localparam int unsigned MB_DI_B  = 2;
  localparam int unsigned MB_DO_B  = 3;
  localparam int unsigned MOD_SK_B = 2;
  localparam int unsigned MOD_CS_B = 4;
  localparam int unsigned MOD_DI_B = 6;
  localparam int unsigned MOD_DO_B = 7;

  localparam int unsigned CHASSIS_LSB = 5;

  typedef struct packed {
    logic cs;
    logic sk;
    logic di;
  } ee_pins_t;
endpackage

// File: rtl/rio_presence.sv
module rio_presence #(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned WORD_W    = 16
) (
  input  logic [NUM_SLOTS-1:0] slot_detect,
  output logic [WORD_W-1:0]    pres_word
);
  // bit b belongs to slot (b mod NUM_SLOTS); a present card pulls it low
  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    assign pres_word[b] = ~slot_detect[b % NUM_SLOTS];
  end
endmodule

// File: rtl/rio_ee_port.sv
module rio_ee_port
  import rio_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned DATA_W    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_mb,
  input  logic                 wr_mod,
  input  logic [DATA_W-1:0]    wdata,
  input  logic                 mb_do,
  input  logic [NUM_SLOTS-1:0] mod_do,
  output logic                 mb_cs,
  output logic                 mb_sk,
  output logic                 mb_di,
  output logic [NUM_SLOTS-1:0] mod_cs,
  output logic [NUM_SLOTS-1:0] mod_sk,
  output logic [NUM_SLOTS-1:0] mod_di,
  output logic                 mb_rd_bit,
  output logic                 mod_rd_bit
);
  localparam int unsigned SEL_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  ee_pins_t          mb_q, mod_q;
  logic [SEL_W-1:0]  sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mb_q  <= '0;
      mod_q <= '0;
      sel_q <= '0;
    end else begin
      if (wr_mb) begin
        mb_q.cs <= wdata[MB_CS_B];
        mb_q.sk <= wdata[MB_SK_B];
        mb_q.di <= wdata[MB_DI_B];
      end
      if (wr_mod) begin
        sel_q    <= wdata[SEL_W-1:0];
        mod_q.cs <= wdata[MOD_CS_B];
        mod_q.sk <= wdata[MOD_SK_B];
        mod_q.di <= wdata[MOD_DI_B];
      end
    end
  end

  assign mb_cs = mb_q.cs;
  assign mb_sk = mb_q.sk;
  assign mb_di = mb_q.di;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic hit;
    assign hit       = (sel_q == SEL_W'(s));
    assign mod_cs[s] = hit & mod_q.cs;
    assign mod_sk[s] = hit & mod_q.sk;
    assign mod_di[s] = hit & mod_q.di;
  end

  assign mb_rd_bit  = mb_do;
  assign mod_rd_bit = mod_do[sel_q];

  // R5
  mb_pins_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mb |=> (mb_cs == $past(wdata[MB_CS_B])) && (mb_sk == $past(wdata[MB_SK_B]))
              && (mb_di == $past(wdata[MB_DI_B])));
  // R6
  mod_cs_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mod |=> mod_cs == (NUM_SLOTS'($past(wdata[MOD_CS_B])) << $past(wdata[SEL_W-1:0])));
  // R6
  mod_one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mod_sk | mod_cs | mod_di));
endmodule

// File: rtl/rio_irq_line.sv
module rio_irq_line #(
  parameter int unsigned CLR_COUNT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_pulse,
  input  logic access,
  output logic irq
);
  localparam int unsigned CW = (CLR_COUNT > 1) ? $clog2(CLR_COUNT) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLR_COUNT - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = access && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      irq <= 1'b0;
    end else begin
      if (access) cnt <= wrap ? '0 : cnt + CW'(1);
      if (set_pulse)  irq <= 1'b1;
      else if (wrap)  irq <= 1'b0;
    end
  end

  // R11
  set_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_pulse |=> irq);
  // R8
  fall_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(access));
  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  // R8
  idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !access |=> $stable(cnt));
endmodule

// File: rtl/rio_ctrl.sv
module rio_ctrl
  import rio_pkg::*;
#(
  parameter int unsigned NUM_SLOTS     = 4,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned MASK_W        = 8,
  parameter int unsigned NET_CLR_COUNT = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [RIO_AW-1:0]    addr,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  input  logic [2:0]           chassis_code,
  input  logic [NUM_SLOTS-1:0] slot_detect,
  output logic                 mb_cs,
  output logic                 mb_sk,
  output logic                 mb_di,
  input  logic                 mb_do,
  output logic [NUM_SLOTS-1:0] mod_cs,
  output logic [NUM_SLOTS-1:0] mod_sk,
  output logic [NUM_SLOTS-1:0] mod_di,
  input  logic [NUM_SLOTS-1:0] mod_do,
  input  logic                 net_set,
  input  logic                 mgmt_set,
  input  logic                 ext_set,
  output logic                 net_irq,
  output logic                 mgmt_irq,
  output logic                 ext_irq
);
  localparam logic [RIO_AW-1:0] NET_LAST = A_NET0 + RIO_AW'(NUM_SLOTS - 1);

  logic               acc;
  logic               in_net;
  logic               mapped;
  logic [MASK_W-1:0]  mask_q;
  logic [DATA_W-1:0]  pres_word;
  logic [DATA_W-1:0]  rd_word;
  logic               mb_rd_bit, mod_rd_bit;

  assign acc    = rd_en | wr_en;
  assign in_net = (addr >= A_NET0) && (addr <= NET_LAST);
  assign mapped = (addr <= A_EXT);

  rio_presence #(.NUM_SLOTS(NUM_SLOTS), .WORD_W(DATA_W)) u_pres (
    .slot_detect (slot_detect),
    .pres_word   (pres_word)
  );

  rio_ee_port #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) u_ee (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_mb      (wr_en && addr == A_MBEE),
    .wr_mod     (wr_en && addr == A_MODEE),
    .wdata      (wdata),
    .mb_do      (mb_do),
    .mod_do     (mod_do),
    .mb_cs      (mb_cs),
    .mb_sk      (mb_sk),
    .mb_di      (mb_di),
    .mod_cs     (mod_cs),
    .mod_sk     (mod_sk),
    .mod_di     (mod_di),
    .mb_rd_bit  (mb_rd_bit),
    .mod_rd_bit (mod_rd_bit)
  );

  rio_irq_line #(.CLR_COUNT(NET_CLR_COUNT)) u_net (
    .clk (clk), .rst_n (rst_n), .set_pulse (net_set),
    .access (acc && in_net), .irq (net_irq)
  );
  rio_irq_line #(.CLR_COUNT(1)) u_mgmt (
    .clk (clk), .rst_n (rst_n), .set_pulse (mgmt_set),
    .access (acc && addr == A_MGMT), .irq (mgmt_irq)
  );
  rio_irq_line #(.CLR_COUNT(1)) u_ext (
    .clk (clk), .rst_n (rst_n), .set_pulse (ext_set),
    .access (acc && addr == A_EXT), .irq (ext_irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else if (wr_en && addr == A_MASK) mask_q <= wdata[MASK_W-1:0];
  end

  always_comb begin
    rd_word = '0;
    if (in_net) begin
      rd_word = NET_WORD;
    end else begin
      case (addr)
        A_FLASH:   rd_word = FLASH_WORD;
        A_BOOT:    rd_word = BOOT_WORD;
        A_CHASSIS: rd_word[CHASSIS_LSB +: 3] = chassis_code;
        A_ENV:     rd_word = ENV_WORD;
        A_PRES:    rd_word = pres_word;
        A_MASK:    rd_word[MASK_W-1:0] = mask_q;
        A_MBEE:    rd_word[MB_DO_B] = mb_rd_bit;
        A_MODEE:   rd_word[MOD_DO_B] = mod_rd_bit;
        default:   rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_en ? rd_word : '0;
  end

  // R13
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> rdata == '0);
  // R12
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !mapped) |=> rdata == '0);
  // R4
  mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_MASK) |=> rdata[DATA_W-1:MASK_W] == '0);
  // R3
  pres_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_PRES) |=>
      $countones(~rdata) == (DATA_W / NUM_SLOTS) * $countones($past(slot_detect)));
endmodule

// File: tb/rio_ctrl_bench.sv
module rio_ctrl_bench;
  import rio_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [2:0]  chassis_code = '0;
  logic [3:0]  slot_detect = '0;
  logic        mb_cs, mb_sk, mb_di, mb_do = 1'b0;
  logic [3:0]  mod_cs, mod_sk, mod_di, mod_do = '0;
  logic        net_set = 1'b0, mgmt_set = 1'b0, ext_set = 1'b0;
  logic        net_irq, mgmt_irq, ext_irq;

  int checks = 0;
  int fails  = 0;
  int net_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rio_ctrl u_rio_ctrl (
    .clk (clk), .rst_n (rst_n), .addr (addr), .wr_en (wr_en), .rd_en (rd_en),
    .wdata (wdata), .rdata (rdata), .chassis_code (chassis_code),
    .slot_detect (slot_detect), .mb_cs (mb_cs), .mb_sk (mb_sk), .mb_di (mb_di),
    .mb_do (mb_do), .mod_cs (mod_cs), .mod_sk (mod_sk), .mod_di (mod_di),
    .mod_do (mod_do), .net_set (net_set), .mgmt_set (mgmt_set), .ext_set (ext_set),
    .net_irq (net_irq), .mgmt_irq (mgmt_irq), .ext_irq (ext_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one bus access with optional set pulses in the same cycle
  task automatic bus(input bit wr, input logic [5:0] a, input logic [15:0] d,
                     input logic [2:0] pulse, output logic [15:0] q);
    @(negedge clk);
    addr = a; wdata = d; wr_en = wr; rd_en = !wr;
    {net_set, mgmt_set, ext_set} = pulse;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; {net_set, mgmt_set, ext_set} = 3'b000;
    q = rdata;
    if (a >= A_NET0 && a <= A_NET0 + 6'd3) net_cnt = (net_cnt + 1) % 16;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] q);
    bus(1'b0, a, 16'h0, 3'b000, q);
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    logic [15:0] unused;
    bus(1'b1, a, d, 3'b000, unused);
  endtask

  task automatic pulse(input logic [2:0] p);
    @(negedge clk);
    {net_set, mgmt_set, ext_set} = p;
    @(negedge clk);
    {net_set, mgmt_set, ext_set} = 3'b000;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [15:0] q;
    logic [15:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 irqs", {net_irq, mgmt_irq, ext_irq}, 0);
    check("R1 rdata", rdata, 0);
    check("R1 mb pins", {mb_cs, mb_sk, mb_di}, 0);
    check("R1 mod pins", {mod_cs, mod_sk, mod_di}, 0);
    rd(A_MASK, q); check("R1 mask", q, 0);
    mod_do = 4'b0001; rd(A_MODEE, q); check("R1 select slot 0", q, 16'h0080);
    mod_do = 4'b0000;

    // R2 fixed words
    rd(A_FLASH, q); check("R2 flash", q, 16'h00FF);
    rd(A_BOOT, q);  check("R2 boot", q, 16'h1000);
    rd(A_ENV, q);   check("R2 env", q, 16'h0021);
    for (int c = 0; c < 8; c++) begin
      chassis_code = 3'(c);
      rd(A_CHASSIS, q); check("R2 chassis", q, 16'(c) << 5);
    end

    // R3 presence, all patterns
    for (int p = 0; p < 16; p++) begin
      slot_detect = 4'(p);
      e = 16'hFFFF;
      for (int s = 0; s < 4; s++) if (p[s]) e &= ~(16'h1111 << s);
      rd(A_PRES, q); check("R3 presence", q, e);
    end

    // R4 mask sweep, R13 idle zero
    for (int v = 0; v < 256; v++) begin
      wr(A_MASK, 16'hA500 | 16'(v));
      rd(A_MASK, q); check("R4 mask", q, 16'(v));
    end
    @(negedge clk); check("R13 idle rdata", rdata, 0);

    // R5 mainboard EEPROM
    for (int v = 0; v < 8; v++) begin
      wr(A_MBEE, 16'(v) | 16'hFFF0);
      check("R5 mb pins", {mb_di, mb_sk, mb_cs}, 32'(v));
    end
    for (int b = 0; b < 2; b++) begin
      mb_do = 1'(b); rd(A_MBEE, q); check("R5 mb read", q, 16'(b) << 3);
    end

    // R6 module EEPROM, every slot and pin combination
    for (int s = 0; s < 4; s++) begin
      for (int v = 0; v < 8; v++) begin
        wr(A_MODEE, 16'(s) | (16'(v & 1) << 4) | (16'((v >> 1) & 1) << 2) | (16'((v >> 2) & 1) << 6));
        check("R6 mod cs", mod_cs, 32'(v & 1) << s);
        check("R6 mod sk", mod_sk, 32'((v >> 1) & 1) << s);
        check("R6 mod di", mod_di, 32'((v >> 2) & 1) << s);
      end
      for (int d = 0; d < 16; d++) begin
        mod_do = 4'(d);
        rd(A_MODEE, q); check("R6 mod read", q, 16'((d >> s) & 1) << 7);
      end
    end

    // R7 R8 network line over 16 mixed accesses
    pulse(3'b100);
    check("R11 net set", net_irq, 1);
    for (int i = 0; i < 16; i++) begin
      if (i % 2 == 0) begin
        rd(A_NET0 + 6'(i % 4), q); check("R7 net word", q, 16'h00FF);
      end else begin
        wr(A_NET0 + 6'(i % 4), 16'h1234);
      end
      check("R8 net line", net_irq, (net_cnt == 0) ? 0 : 1);
    end
    // R8 count advances while line is low
    for (int i = 0; i < 5; i++) rd(A_NET0 + 6'd3, q);
    pulse(3'b100);
    while (net_cnt != 15) rd(A_NET0 + 6'd1, q);
    check("R8 net before 16th", net_irq, 1);
    rd(A_NET0 + 6'd2, q); check("R8 net after 16th", net_irq, 0);
    // R11 set with the clearing access
    for (int i = 0; i < 15; i++) rd(A_NET0, q);
    bus(1'b0, A_NET0, 16'h0, 3'b100, q);
    check("R11 net set wins", net_irq, 1);

    // R9 R10
    pulse(3'b010); rd(A_MGMT, q);
    check("R9 mgmt read", q, 0); check("R9 mgmt cleared", mgmt_irq, 0);
    pulse(3'b010); wr(A_MGMT, 16'hFFFF); check("R9 mgmt write clears", mgmt_irq, 0);
    pulse(3'b001); rd(A_EXT, q);
    check("R10 ext read", q, 0); check("R10 ext cleared", ext_irq, 0);
    pulse(3'b001); wr(A_EXT, 16'hFFFF); check("R10 ext write clears", ext_irq, 0);
    bus(1'b0, A_MGMT, 16'h0, 3'b010, q); check("R11 mgmt set wins", mgmt_irq, 1);
    bus(1'b1, A_EXT, 16'h0, 3'b001, q);  check("R11 ext set wins", ext_irq, 1);

    // R12 unmapped and read-only writes
    wr(A_MASK, 16'h005A);
    wr(A_MBEE, 16'h0005);
    wr(A_MODEE, 16'h0052);
    for (int a = 14; a < 64; a++) begin
      wr(6'(a), 16'hFFFF);
      rd(6'(a), q); check("R12 unmapped read", q, 0);
    end
    wr(A_FLASH, 16'h0000); wr(A_BOOT, 16'h0000); wr(A_ENV, 16'h0000);
    rd(A_FLASH, q); check("R12 flash unchanged", q, 16'h00FF);
    rd(A_ENV, q);   check("R12 env unchanged", q, 16'h0021);
    rd(A_MASK, q);  check("R12 mask unchanged", q, 16'h005A);
    check("R12 mb pins unchanged", {mb_di, mb_sk, mb_cs}, 3'b101);
    check("R12 mod pins unchanged", {mod_cs, mod_sk, mod_di}, 12'h404);
    check("R12 irqs unchanged", {net_irq, mgmt_irq, ext_irq}, 3'b111);

    done = 1'b1;
    summary();
  end
endmodule